// File: doc/BRIEF.md
# Interrupt Enable and Pending Register Bank

This block holds the enable and pending state for a group of up to 32 interrupt lines packed into one bus word. Software never modifies that state with a read-modify-write sequence. Instead, four word addresses each act on one state bit per line:

- one address turns enables on,
- one turns enables off,
- one marks lines pending,
- one withdraws pending requests.

On each of these addresses, a written 1 acts on its line and a written 0 does nothing. So a single bus write changes exactly the chosen lines, and it cannot disturb any line it does not name.

Peripherals raise requests on `irq_req`. A rising edge on a line marks that line pending, whether or not the line is enabled. Each line has a small two-state edge tracker with the states LINE_IDLE and LINE_ASSERTED:

- LINE_IDLE to LINE_ASSERTED happens when the request is seen high, and this transition produces the pending pulse.
- LINE_ASSERTED to LINE_IDLE happens when the request is seen low.

For each line, the bank drives a registered `irq_active` flag that is high when the line is both enabled and pending. A downstream arbiter consumes these flags.

Reads use a single-cycle register bus. Address bit 1 selects the group: 0 selects enable, 1 selects pending. Both the set address and the clear address of a group read back the live state of that group.

Top module: `irq_enpend_bank`

## Requirements
- R1: A write to address 0 sets the enable bit of every line whose data bit is 1. Lines whose data bit is 0 keep their enable bit.
- R2: A write to address 1 clears the enable bit of every line whose data bit is 1. Lines whose data bit is 0 keep their enable bit.
- R3: A read of address 0 or address 1 returns the live enable word. `bus_rdata` is valid from the clock edge that accepts the read and holds until the next read.
- R4: A read of address 2 or address 3 returns the live pending word, with the same timing as R3.
- R5: A low-to-high transition seen on `irq_req[i]` sets pending bit i at that clock edge, whether or not line i is enabled. A request held high causes no further setting after it is cleared.
- R6: A write to address 3 clears the pending bit of every line whose data bit is 1. Lines whose data bit is 0 keep their pending bit.
- R7: A write to address 2 sets the pending bit of every line whose data bit is 1.
- R8: Clearing an enable bit leaves the pending bit of that line unchanged. Only a write to address 3 ever clears pending state.
- R9: If a request edge and a clear-pending write hit the same line in the same cycle, the line ends up pending.
- R10: `irq_active` equals the enable word AND the pending word, delayed by exactly one clock edge.
- R11: After reset, all enable bits, pending bits, `irq_active` and `bus_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access strobe, one cycle per access |
| bus_write | input | 1 | 1 selects a write, 0 selects a read |
| bus_addr | input | 2 | Word select: 0 enable-set, 1 enable-clear, 2 pending-set, 3 pending-clear |
| bus_wdata | input | NUM_LINES | Write data, one bit per line |
| bus_rdata | output | NUM_LINES | Registered read data |
| irq_req | input | NUM_LINES | Peripheral request levels |
| irq_active | output | NUM_LINES | Registered per-line enabled-and-pending flag |

## Verification
The hardest case to reach from the ports is the same-cycle collision between a new request edge and a clear-pending write that names that line. Reaching it requires the request line to be returned low first, so that its tracker sits in LINE_IDLE. The bench does this, then raises the request on the same falling edge at which it launches the clear write. A second hard case is a request held high across a clear. To produce it, the bench keeps the lines high, clears pending, and expects no re-arming. Beyond these cases, the bench sweeps every 8-bit set and clear pattern against an arithmetic model of both words.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int unsigned BUS_ADDR_W = 2;

    typedef enum logic [BUS_ADDR_W-1:0] {
        REG_EN_SET = 2'd0,
        REG_EN_CLR = 2'd1,
        REG_PD_SET = 2'd2,
        REG_PD_CLR = 2'd3
    } reg_sel_e;

    typedef enum logic {
        LINE_IDLE     = 1'b0,
        LINE_ASSERTED = 1'b1
    } line_state_e;

endpackage

// File: rtl/irq_edge_fsm.sv
module irq_edge_fsm
    import irq_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic rise
);

    line_state_e state_q;
    line_state_e state_d;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_IDLE:     if (req)  state_d = LINE_ASSERTED;
            LINE_ASSERTED: if (!req) state_d = LINE_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_IDLE;
        else        state_q <= state_d;
    end

    // Output process: pulse on the LINE_IDLE -> LINE_ASSERTED transition.
    always_comb begin
        rise = 1'b0;
        unique case (state_q)
            LINE_IDLE:     rise = req;
            LINE_ASSERTED: rise = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_bank_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32
) (
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic [NUM_LINES-1:0]  bus_wdata,
    output logic [NUM_LINES-1:0]  en_set,
    output logic [NUM_LINES-1:0]  en_clr,
    output logic [NUM_LINES-1:0]  pd_set,
    output logic [NUM_LINES-1:0]  pd_clr,
    output logic                  rd_stb,
    output logic                  rd_pend
);

    reg_sel_e sel;

    assign sel     = reg_sel_e'(bus_addr);
    assign rd_stb  = bus_valid && !bus_write;
    assign rd_pend = (sel == REG_PD_SET) || (sel == REG_PD_CLR);

    always_comb begin
        en_set = '0;
        en_clr = '0;
        pd_set = '0;
        pd_clr = '0;
        if (bus_valid && bus_write) begin
            unique case (sel)
                REG_EN_SET: en_set = bus_wdata;
                REG_EN_CLR: en_clr = bus_wdata;
                REG_PD_SET: pd_set = bus_wdata;
                REG_PD_CLR: pd_clr = bus_wdata;
            endcase
        end
    end

endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs #(
    parameter int unsigned NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] en_set,
    input  logic [NUM_LINES-1:0] en_clr,
    input  logic [NUM_LINES-1:0] pd_set,
    input  logic [NUM_LINES-1:0] pd_clr,
    input  logic [NUM_LINES-1:0] hw_rise,
    output logic [NUM_LINES-1:0] en_q,
    output logic [NUM_LINES-1:0] pend_q,
    output logic [NUM_LINES-1:0] act_q
);

    logic [NUM_LINES-1:0] en_d;
    logic [NUM_LINES-1:0] pend_d;

    always_comb begin
        en_d   = (en_q | en_set) & ~en_clr;
        // Hardware edge is ORed last so it wins over a clear.
        pend_d = ((pend_q | pd_set) & ~pd_clr) | hw_rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            en_q   <= en_d;
            pend_q <= pend_d;
            act_q  <= en_q & pend_q;
        end
    end

endmodule

// File: rtl/irq_enpend_bank.sv
module irq_enpend_bank
    import irq_bank_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic [NUM_LINES-1:0]  bus_wdata,
    output logic [NUM_LINES-1:0]  bus_rdata,
    input  logic [NUM_LINES-1:0]  irq_req,
    output logic [NUM_LINES-1:0]  irq_active
);

    logic [NUM_LINES-1:0] en_set, en_clr, pd_set, pd_clr;
    logic [NUM_LINES-1:0] hw_rise;
    logic [NUM_LINES-1:0] en_q, pend_q;
    logic                 rd_stb, rd_pend;
    logic [NUM_LINES-1:0] rdata_q;

    irq_bus_decode #(.NUM_LINES(NUM_LINES)) decode_i (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .en_set    (en_set),
        .en_clr    (en_clr),
        .pd_set    (pd_set),
        .pd_clr    (pd_clr),
        .rd_stb    (rd_stb),
        .rd_pend   (rd_pend)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        irq_edge_fsm edge_i (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (irq_req[i]),
            .rise  (hw_rise[i])
        );
    end

    irq_state_regs #(.NUM_LINES(NUM_LINES)) state_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_set  (en_set),
        .en_clr  (en_clr),
        .pd_set  (pd_set),
        .pd_clr  (pd_clr),
        .hw_rise (hw_rise),
        .en_q    (en_q),
        .pend_q  (pend_q),
        .act_q   (irq_active)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_stb) rdata_q <= rd_pend ? pend_q : en_q;
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/irq_enpend_bank_chk.sv
module irq_enpend_bank_chk #(
    parameter int unsigned NUM_LINES = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_valid,
    input logic                 bus_write,
    input logic [1:0]           bus_addr,
    input logic [NUM_LINES-1:0] bus_wdata,
    input logic [NUM_LINES-1:0] bus_rdata,
    input logic [NUM_LINES-1:0] irq_req,
    input logic [NUM_LINES-1:0] irq_active,
    input logic [NUM_LINES-1:0] en_state,
    input logic [NUM_LINES-1:0] pend_state
);

    logic [NUM_LINES-1:0] req_seen;
    logic [NUM_LINES-1:0] req_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_seen <= '0;
        else        req_seen <= irq_req;
    end
    assign req_edge = irq_req & ~req_seen;

    // R1
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == 2'd0)
        |=> ((en_state & $past(bus_wdata)) == $past(bus_wdata)));

    // R2
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == 2'd1)
        |=> ((en_state & $past(bus_wdata)) == '0));

    // R3
    rd_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write)
        |=> (bus_rdata == ($past(bus_addr[1]) ? $past(pend_state) : $past(en_state))));

    // R9
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_edge != '0) |=> ((pend_state & $past(req_edge)) == $past(req_edge)));

    // R8
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write && bus_addr == 2'd3)
        |=> ((pend_state & $past(pend_state)) == $past(pend_state)));

    // R10
    active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_active == $past(en_state & pend_state)));

endmodule

bind irq_enpend_bank irq_enpend_bank_chk #(.NUM_LINES(NUM_LINES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_req    (irq_req),
    .irq_active (irq_active),
    .en_state   (en_q),
    .pend_state (pend_q)
);

// File: tb/irq_enpend_bank_tb_top.sv
`timescale 1ns/1ps
module irq_enpend_bank_tb_top;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_valid = 1'b0;
    logic         bus_write = 1'b0;
    logic [1:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic [N-1:0] irq_req = '0;
    logic [N-1:0] irq_active;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] exp_en = '0;
    logic [N-1:0] exp_pd = '0;

    always #10 clk = ~clk;

    irq_enpend_bank #(.NUM_LINES(N)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_req    (irq_req),
        .irq_active (irq_active)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        case (a)
            2'd0: exp_en = exp_en | d;
            2'd1: exp_en = exp_en & ~d;
            2'd2: exp_pd = exp_pd | d;
            default: exp_pd = exp_pd & ~d;
        endcase
    endtask

    task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [N-1:0] r;
        logic [N-1:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state on all four addresses
        check("R11 active", irq_active, '0);
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], r);
            check("R11 read", r, '0);
        end

        // Enable sweep: R1, R2, R3, R10
        for (int v = 0; v < 256; v++) begin
            wr(2'd1, 8'hFF);
            wr(2'd0, v[7:0]);
            wr(2'd0, 8'h00);
            rd(2'd1, r);
            check("R3 R1 enable via clear alias", r, v[7:0]);
            w = 8'((v * 37 + 11) & 8'hFF);
            wr(2'd1, w);
            rd(2'd0, r);
            check("R2 enable after clear", r, v[7:0] & ~w);
            check("R10 active", irq_active, exp_en & exp_pd);
        end

        // Pending sweep: R7, R6, R4, R10
        wr(2'd0, 8'hA5);
        for (int v = 0; v < 256; v++) begin
            wr(2'd3, 8'hFF);
            wr(2'd2, v[7:0]);
            rd(2'd3, r);
            check("R4 R7 pending via clear alias", r, v[7:0]);
            w = 8'((v * 91 + 3) & 8'hFF);
            wr(2'd3, w);
            wr(2'd3, 8'h00);
            rd(2'd2, r);
            check("R6 pending after clear", r, v[7:0] & ~w);
            check("R10 active", irq_active, exp_en & exp_pd);
        end

        // R5 per-line request edges with all lines disabled
        wr(2'd1, 8'hFF);
        wr(2'd3, 8'hFF);
        for (int i = 0; i < N; i++) begin
            irq_req = N'(1) << i;
            @(negedge clk);
            exp_pd = exp_pd | (N'(1) << i);
            irq_req = '0;
            rd(2'd2, r);
            check("R5 edge sets pending while disabled", r, exp_pd);
        end
        check("R5 active stays low", irq_active, '0);

        // R5 held level does not re-arm after clear
        irq_req = 8'hFF;
        @(negedge clk);
        wr(2'd3, 8'hFF);
        repeat (3) @(negedge clk);
        rd(2'd2, r);
        check("R5 held request no re-set", r, 8'h00);

        // R9 edge and clear-pending collide
        irq_req = '0;
        @(negedge clk);
        wr(2'd2, 8'h03);
        irq_req = 8'h3C;
        wr(2'd3, 8'hFF);
        exp_pd = 8'h3C;
        irq_req = '0;
        rd(2'd3, r);
        check("R9 edge beats clear", r, 8'h3C);

        // R8 disabling keeps pending
        wr(2'd3, 8'hFF);
        wr(2'd0, 8'hFF);
        wr(2'd2, 8'h81);
        rd(2'd0, r);
        check("R10 enabled and pending", irq_active, 8'h81);
        wr(2'd1, 8'hFF);
        rd(2'd2, r);
        check("R8 pending survives disable", r, 8'h81);
        check("R8 active dropped", irq_active, 8'h00);
        wr(2'd0, 8'h01);
        rd(2'd0, r);
        check("R8 re-enable shows pending again", irq_active, 8'h01);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule